// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a three-wire serial write port that fills a bank of configuration registers for an eight-channel clock distribution and PLL core. A host drives a serial clock, a serial data line and a latch line. Bits enter a 32-bit shift register most significant bit first. When the latch line rises, the low four bits of the shifted word select a target register and the upper 28 bits are written into it. No read path exists.

The three serial lines are asynchronous to the core. They are oversampled in the system clock domain through a synchronizer, and their rising edges are detected there. The decoded register contents leave the block as flat buses: per-channel mode, enable, divide code and delay; one lock-detect prescale bit; a PLL control group (global output enable, power-down, pump tri-state, pump polarity, status pin mode, reference divider); and a PLL feedback group (pump gain, feedback divider). A flag bit in the channel 0 word returns the whole bank to its default values.

Top module: `sercfg_port`

## Requirements
- R1: After `rst_n` is asserted, every channel has mode 0, enable 0, divide code 1 and delay 0. The prescale bit is 0. Global enable is 1. Power-down, tri-state, polarity, pin mode and gain are 0. The reference divider is 10 and the feedback divider is 760.
- R2: Each rising edge of `serClk` seen while `serLatch` is low shifts `serData` into bit 0 of a 32-bit word, with earlier bits moving toward bit 31. A rising edge of `serLatch` commits the word to the address held in bits [3:0].
- R3: A committed word with address a in 0..7 (and bit 31 clear when a is 0) sets channel a as follows: mode from bits [18:17], enable from bit 16, divide code from bits [15:8] and delay from bits [7:4]. Other channels are unchanged.
- R4: A word with address 14 sets the PLL control group. Global enable comes from bit 27, power-down from bit 26, tri-state from bit 25, polarity from bit 24, pin mode from bits [23:20] and the reference divider from bits [19:8].
- R5: A word with address 15 sets the pump gain from bits [31:30] and the feedback divider from bits [25:8].
- R6: A word with address 11 sets the prescale bit from bit 15.
- R7: A word with address 0 and bit 31 set restores every register to its R1 value. Its other bits are discarded, so channel 0 also takes its default.
- R8: A word with address 8, 9, 10, 12 or 13 changes no output.
- R9: Rising edges of `serClk` while `serLatch` is high do not shift. A second latch pulse with no new bits commits the same word again.
- R10: The shift register is not cleared by a commit. After a commit, shifting k more bits b forms the word (previous << k) | b.
- R11: Outputs change only as a result of a commit. They take the new value on the third rising edge of `clk` after the first `clk` edge that samples `serLatch` high, and they hold their old value before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial shift clock (asynchronous) |
| serData | input | 1 | Serial data, MSB first |
| serLatch | input | 1 | Latch line; its rising edge commits the word |
| chMode | output | 16 | Channel mode, channel i at [2i+1:2i] |
| chEnable | output | 8 | Channel enable, channel i at bit i |
| chDivCode | output | 64 | Channel divide code, channel i at [8i+7:8i] |
| chDelay | output | 32 | Channel delay code, channel i at [4i+3:4i] |
| lockPrescale | output | 1 | Lock-detect prescale select |
| outGlobalEn | output | 1 | Global output enable |
| powerDown | output | 1 | Core power-down |
| pumpTristate | output | 1 | Charge pump tri-state |
| pumpPolarity | output | 1 | Charge pump polarity |
| statusPinMode | output | 4 | Status pin mode select |
| refDivider | output | 12 | PLL reference divider |
| fbDivider | output | 18 | PLL feedback divider |
| pumpGain | output | 2 | Charge pump gain code |

## Verification
Each serial line passes two synchronizer stages and one edge-detect register. A shift or a commit therefore takes effect on the third system clock edge after the edge that first samples the new line level. The bench changes the serial lines only on falling clock edges and holds each phase for three clock cycles. It samples the outputs at least four falling edges after a latch rise. One sequence probes the exact cycle: the second falling edge after the latch rise must still show the old value, and the third must show the new one. Expected register contents come from an arithmetic model of the shifted word that the bench updates bit by bit.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  localparam int NUM_CH    = 8;
  localparam int WORD_W    = 32;
  localparam int ADDR_W    = 4;
  localparam int MODE_W    = 2;
  localparam int DIV_W     = 8;
  localparam int DLY_W     = 4;
  localparam int PINMODE_W = 4;
  localparam int RDIV_W    = 12;
  localparam int NDIV_W    = 18;
  localparam int GAIN_W    = 2;

  localparam int ADDR_PRESCALE = 11;
  localparam int ADDR_PLL_CTRL = 14;
  localparam int ADDR_PLL_FB   = 15;

  localparam int SOFT_RST_BIT = 31;
  localparam int PRESCALE_BIT = 15;
  localparam int CH_LSB       = 4;
  localparam int PLLA_LSB     = 8;
  localparam int NDIV_LSB     = 8;
  localparam int GAIN_LSB     = 30;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              en;
    logic [DIV_W-1:0]  div;
    logic [DLY_W-1:0]  dly;
  } chCfg_t;

  typedef struct packed {
    logic                 globalEn;
    logic                 powerDown;
    logic                 cpTri;
    logic                 cpPol;
    logic [PINMODE_W-1:0] pinMode;
    logic [RDIV_W-1:0]    refDiv;
  } pllA_t;

  typedef struct packed {
    logic [GAIN_W-1:0] gain;
    logic [NDIV_W-1:0] fbDiv;
  } pllB_t;

  typedef struct packed {
    logic shiftEn;
    logic bitIn;
    logic commit;
  } strobe_t;

  localparam int CH_W   = $bits(chCfg_t);
  localparam int PLLA_W = $bits(pllA_t);

  localparam chCfg_t CH_DEFAULT = '{mode: '0, en: 1'b0, div: DIV_W'(1), dly: '0};
  localparam pllA_t PLLA_DEFAULT = '{globalEn: 1'b1, powerDown: 1'b0, cpTri: 1'b0,
                                     cpPol: 1'b0, pinMode: '0, refDiv: RDIV_W'(10)};
  localparam pllB_t PLLB_DEFAULT = '{gain: '0, fbDiv: NDIV_W'(760)};
endpackage

// File: rtl/sercfg_ctrl.sv
module sercfg_ctrl
  import sercfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    serClk,
  input  logic    serData,
  input  logic    serLatch,
  output strobe_t stb
);
  localparam int LINES = 3;

  logic [SYNC_STAGES-1:0][LINES-1:0] pipe;
  logic [LINES-1:0] synced;
  logic prevClk;
  logic prevLatch;

  // bit 0: clock, bit 1: data, bit 2: latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe      <= '0;
      prevClk   <= 1'b0;
      prevLatch <= 1'b0;
    end else begin
      pipe[0] <= {serLatch, serData, serClk};
      for (int s = 1; s < SYNC_STAGES; s++) pipe[s] <= pipe[s-1];
      prevClk   <= synced[0];
      prevLatch <= synced[2];
    end
  end

  assign synced = pipe[SYNC_STAGES-1];

  always_comb begin
    stb.shiftEn = synced[0] & ~prevClk & ~synced[2];
    stb.bitIn   = synced[1];
    stb.commit  = synced[2] & ~prevLatch;
  end

  AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stb.commit |=> !stb.commit); // R11
endmodule

// File: rtl/sercfg_regs.sv
module sercfg_regs
  import sercfg_pkg::*;
#(
  parameter int NCH = NUM_CH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  strobe_t              stb,
  output chCfg_t [NCH-1:0]     chCfg,
  output pllA_t                pllA,
  output pllB_t                pllB,
  output logic                 prescale
);
  logic [WORD_W-1:0] shReg;
  logic [ADDR_W-1:0] wAddr;
  logic              softRst;
  logic              addrListed;

  assign wAddr   = shReg[ADDR_W-1:0];
  assign softRst = stb.commit && (wAddr == '0) && shReg[SOFT_RST_BIT];

  always_comb begin
    addrListed = (32'(wAddr) < NCH)
              || (32'(wAddr) == ADDR_PRESCALE)
              || (32'(wAddr) == ADDR_PLL_CTRL)
              || (32'(wAddr) == ADDR_PLL_FB);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shReg <= '0;
    else if (stb.shiftEn) shReg <= {shReg[WORD_W-2:0], stb.bitIn};
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    chCfg_t chQ;
    logic   chWe;
    assign chWe = stb.commit && !softRst && (wAddr == ADDR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       chQ <= CH_DEFAULT;
      else if (softRst) chQ <= CH_DEFAULT;
      else if (chWe)    chQ <= chCfg_t'(shReg[CH_LSB +: CH_W]);
    end
    assign chCfg[i] = chQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pllA     <= PLLA_DEFAULT;
      pllB     <= PLLB_DEFAULT;
      prescale <= 1'b0;
    end else if (softRst) begin
      pllA     <= PLLA_DEFAULT;
      pllB     <= PLLB_DEFAULT;
      prescale <= 1'b0;
    end else if (stb.commit) begin
      if (32'(wAddr) == ADDR_PRESCALE) prescale <= shReg[PRESCALE_BIT];
      if (32'(wAddr) == ADDR_PLL_CTRL) pllA <= pllA_t'(shReg[PLLA_LSB +: PLLA_W]);
      if (32'(wAddr) == ADDR_PLL_FB) begin
        pllB.gain  <= shReg[GAIN_LSB +: GAIN_W];
        pllB.fbDiv <= shReg[NDIV_LSB +: NDIV_W];
      end
    end
  end

  AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    stb.shiftEn |=> (shReg[0] == $past(stb.bitIn))
                 && (shReg[WORD_W-1:1] == $past(shReg[WORD_W-2:0]))); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.commit |=> $stable(chCfg) && $stable(pllA) && $stable(pllB)
                 && $stable(prescale)); // R11

  AST_SOFT_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    softRst |=> (chCfg == {NCH{CH_DEFAULT}}) && (pllA == PLLA_DEFAULT)
             && (pllB == PLLB_DEFAULT) && !prescale); // R7

  AST_UNLISTED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.commit && !addrListed) |=> $stable(chCfg) && $stable(pllA)
                                 && $stable(pllB) && $stable(prescale)); // R8
endmodule

// File: rtl/sercfg_port.sv
module sercfg_port
  import sercfg_pkg::*;
#(
  parameter int NCH         = NUM_CH,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    serClk,
  input  logic                    serData,
  input  logic                    serLatch,
  output logic [NCH*MODE_W-1:0]   chMode,
  output logic [NCH-1:0]          chEnable,
  output logic [NCH*DIV_W-1:0]    chDivCode,
  output logic [NCH*DLY_W-1:0]    chDelay,
  output logic                    lockPrescale,
  output logic                    outGlobalEn,
  output logic                    powerDown,
  output logic                    pumpTristate,
  output logic                    pumpPolarity,
  output logic [PINMODE_W-1:0]    statusPinMode,
  output logic [RDIV_W-1:0]       refDivider,
  output logic [NDIV_W-1:0]       fbDivider,
  output logic [GAIN_W-1:0]       pumpGain
);
  strobe_t          stb;
  chCfg_t [NCH-1:0] chCfg;
  pllA_t            pllA;
  pllB_t            pllB;

  sercfg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .serClk(serClk), .serData(serData),
    .serLatch(serLatch), .stb(stb)
  );

  sercfg_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .stb(stb), .chCfg(chCfg), .pllA(pllA),
    .pllB(pllB), .prescale(lockPrescale)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_out
    assign chMode[i*MODE_W +: MODE_W] = chCfg[i].mode;
    assign chEnable[i]                = chCfg[i].en;
    assign chDivCode[i*DIV_W +: DIV_W] = chCfg[i].div;
    assign chDelay[i*DLY_W +: DLY_W]   = chCfg[i].dly;
  end

  assign outGlobalEn   = pllA.globalEn;
  assign powerDown     = pllA.powerDown;
  assign pumpTristate  = pllA.cpTri;
  assign pumpPolarity  = pllA.cpPol;
  assign statusPinMode = pllA.pinMode;
  assign refDivider    = pllA.refDiv;
  assign fbDivider     = pllB.fbDiv;
  assign pumpGain      = pllB.gain;
endmodule

// File: tb/sim_sercfg_port.sv
module sim_sercfg_port;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serClk = 1'b0;
  logic serData = 1'b0;
  logic serLatch = 1'b0;
  logic [NCH*2-1:0] chMode;
  logic [NCH-1:0]   chEnable;
  logic [NCH*8-1:0] chDivCode;
  logic [NCH*4-1:0] chDelay;
  logic lockPrescale, outGlobalEn, powerDown, pumpTristate, pumpPolarity;
  logic [3:0]  statusPinMode;
  logic [11:0] refDivider;
  logic [17:0] fbDivider;
  logic [1:0]  pumpGain;

  int nChk = 0;
  int nFail = 0;

  logic [31:0] sh = '0;
  logic [1:0] eMode [NCH];
  logic       eEn   [NCH];
  logic [7:0] eDiv  [NCH];
  logic [3:0] eDly  [NCH];
  logic eGlob, ePd, eTri, ePol, ePre;
  logic [3:0]  ePin;
  logic [11:0] eR;
  logic [17:0] eN;
  logic [1:0]  eGain;

  always #2.5 clk = ~clk;

  sercfg_port u0 (
    .clk(clk), .rst_n(rst_n), .serClk(serClk), .serData(serData), .serLatch(serLatch),
    .chMode(chMode), .chEnable(chEnable), .chDivCode(chDivCode), .chDelay(chDelay),
    .lockPrescale(lockPrescale), .outGlobalEn(outGlobalEn), .powerDown(powerDown),
    .pumpTristate(pumpTristate), .pumpPolarity(pumpPolarity),
    .statusPinMode(statusPinMode), .refDivider(refDivider), .fbDivider(fbDivider),
    .pumpGain(pumpGain)
  );

  task automatic resetModel();
    for (int i = 0; i < NCH; i++) begin
      eMode[i] = 2'd0; eEn[i] = 1'b0; eDiv[i] = 8'd1; eDly[i] = 4'd0;
    end
    eGlob = 1'b1; ePd = 1'b0; eTri = 1'b0; ePol = 1'b0; ePin = 4'd0;
    eR = 12'd10; eN = 18'd760; eGain = 2'd0; ePre = 1'b0;
  endtask

  task automatic applyModel(logic [31:0] w);
    int a;
    a = int'(w[3:0]);
    if (a < NCH) begin
      if (a == 0 && w[31]) resetModel();
      else begin
        eMode[a] = w[18:17]; eEn[a] = w[16]; eDiv[a] = w[15:8]; eDly[a] = w[7:4];
      end
    end else if (a == 11) ePre = w[15];
    else if (a == 14) begin
      eGlob = w[27]; ePd = w[26]; eTri = w[25]; ePol = w[24]; ePin = w[23:20]; eR = w[19:8];
    end else if (a == 15) begin
      eGain = w[31:30]; eN = w[25:8];
    end
  endtask

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    for (int i = 0; i < NCH; i++) begin
      cmp(req, $sformatf("ch%0d mode", i), 32'(chMode[i*2 +: 2]), 32'(eMode[i]));
      cmp(req, $sformatf("ch%0d en", i), 32'(chEnable[i]), 32'(eEn[i]));
      cmp(req, $sformatf("ch%0d div", i), 32'(chDivCode[i*8 +: 8]), 32'(eDiv[i]));
      cmp(req, $sformatf("ch%0d dly", i), 32'(chDelay[i*4 +: 4]), 32'(eDly[i]));
    end
    cmp(req, "globalEn", 32'(outGlobalEn), 32'(eGlob));
    cmp(req, "powerDown", 32'(powerDown), 32'(ePd));
    cmp(req, "tristate", 32'(pumpTristate), 32'(eTri));
    cmp(req, "polarity", 32'(pumpPolarity), 32'(ePol));
    cmp(req, "pinMode", 32'(statusPinMode), 32'(ePin));
    cmp(req, "refDiv", 32'(refDivider), 32'(eR));
    cmp(req, "fbDiv", 32'(fbDivider), 32'(eN));
    cmp(req, "gain", 32'(pumpGain), 32'(eGain));
    cmp(req, "prescale", 32'(lockPrescale), 32'(ePre));
  endtask

  task automatic shiftBits(int n, logic [31:0] v);
    for (int i = n - 1; i >= 0; i--) begin
      serData = v[i];
      repeat (3) @(negedge clk);
      serClk = 1'b1;
      sh = {sh[30:0], v[i]};
      repeat (3) @(negedge clk);
      serClk = 1'b0;
    end
  endtask

  task automatic latchPulse();
    repeat (3) @(negedge clk);
    serLatch = 1'b1;
    repeat (4) @(negedge clk);
    applyModel(sh);
    serLatch = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic sendWord(logic [31:0] w);
    shiftBits(32, w);
    latchPulse();
  endtask

  function automatic logic [31:0] chWord(int a, logic [1:0] m, logic e, logic [7:0] d,
                                         logic [3:0] y, logic [12:0] hi);
    return {hi, m, e, d, y, 4'(a)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    logic [7:0] oldDiv;
    resetModel();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checkAll("R1");

    // R2 R3: channel sweep with noise in upper bits
    for (int p = 0; p < 4; p++) begin
      for (int ch = 0; ch < NCH; ch++) begin
        logic [12:0] hi;
        hi = 13'(ch * 613 + p * 97) & ((ch == 0) ? 13'h0FFF : 13'h1FFF);
        sendWord(chWord(ch, 2'(ch + p), 1'((ch + p) & 1), 8'(ch * 37 + p * 11 + 1),
                        4'(ch * 3 + p * 5), hi));
        checkAll("R2/R3");
      end
    end

    // R4: PLL control group
    for (int k = 0; k < 6; k++) begin
      logic [3:0] fl;
      fl = 4'(k * 5 + 3);
      sendWord({4'(k * 7), fl, 4'(k * 3 + 1), 12'(k * 683 + 1), 4'(k), 4'hE});
      checkAll("R4");
    end

    // R5: PLL feedback group, including extremes
    for (int k = 0; k < 5; k++) begin
      logic [17:0] nv;
      nv = (k == 4) ? 18'h3FFFF : 18'(k * 52429 + 1);
      sendWord({2'(k), 4'(k * 5), nv, 4'(k + 9), 4'hF});
      checkAll("R5");
    end

    // R6: prescale bit
    sendWord({16'hA5A5, 1'b1, 11'h2C3, 4'hB});
    checkAll("R6");
    sendWord({16'hFFFF, 1'b0, 11'h7FF, 4'hB});
    checkAll("R6");
    sendWord({16'h0000, 1'b1, 11'h000, 4'hB});
    checkAll("R6");

    // R8: unlisted addresses leave everything as is
    for (int k = 0; k < 5; k++) begin
      int a;
      a = (k < 3) ? 8 + k : 9 + k;
      sendWord({28'hFFFFFFF ^ 28'(k * 4097), 4'(a)});
      checkAll("R8");
    end

    // R9: clocks while latch is high do not shift
    shiftBits(32, chWord(6, 2'd2, 1'b1, 8'h5C, 4'h9, 13'h0123));
    repeat (3) @(negedge clk);
    serLatch = 1'b1;
    repeat (4) @(negedge clk);
    applyModel(sh);
    for (int i = 0; i < 4; i++) begin
      serData = 1'b1;
      repeat (3) @(negedge clk);
      serClk = 1'b1;
      repeat (3) @(negedge clk);
      serClk = 1'b0;
    end
    serLatch = 1'b0;
    repeat (3) @(negedge clk);
    checkAll("R9");
    latchPulse();
    checkAll("R9");

    // R10: shift register keeps its content across a commit
    sendWord(chWord(3, 2'd1, 1'b1, 8'hC6, 4'h7, 13'h0041));
    shiftBits(4, 32'h5);
    latchPulse();
    checkAll("R10");
    shiftBits(8, 32'h2F);
    latchPulse();
    checkAll("R10");

    // R11: exact commit cycle
    oldDiv = eDiv[5];
    shiftBits(32, chWord(5, 2'd3, 1'b0, ~oldDiv, 4'hA, 13'h0));
    repeat (3) @(negedge clk);
    serLatch = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cmp("R11", "ch5 div before commit edge", 32'(chDivCode[5*8 +: 8]), 32'(oldDiv));
    @(negedge clk);
    applyModel(sh);
    cmp("R11", "ch5 div at commit edge", 32'(chDivCode[5*8 +: 8]), 32'(eDiv[5]));
    serLatch = 1'b0;
    repeat (3) @(negedge clk);
    checkAll("R11");

    // R7: soft reset discards the word and restores defaults
    sendWord({1'b1, 12'hABC, 2'd3, 1'b1, 8'hEE, 4'hD, 4'h0});
    checkAll("R7");
    sendWord(chWord(0, 2'd2, 1'b1, 8'h44, 4'h3, 13'h0FFF));
    checkAll("R7");
    sendWord({1'b1, 31'h0});
    checkAll("R7");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule